// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits between a converter's result path and the result register that software reads. Each finished conversion arrives as one beat on a valid/ready input carrying an unsigned 16-bit result word. The word is either a single sample or an already-averaged value; the block treats both the same way. The block decides whether that word is accepted. An accepted word is stored in the result register and raises a sticky completion flag. A rejected word leaves both untouched, so software only sees values that meet the programmed window condition.

Two thresholds set the window. A range enable picks between a one-threshold test and a two-threshold test. A select bit picks the sense of the test. In range mode, the order of the two thresholds also matters: it decides whether the select bit means inside or outside, and whether the endpoints count. When the compare enable is low, every beat is accepted. The completion flag clears on a read strobe that software issues when it reads the result. The interrupt request follows the flag, gated by an interrupt enable.

The input never applies back-pressure: `conv_ready` is held high, so every cycle with `conv_valid` high is a completed transfer. Thresholds and mode bits are sampled only in the cycle of the valid beat, so writing them between beats affects the next beat. The outputs update at the clock edge that accepts the beat.

Top module: `adcwin_top`

## Requirements
- R1: With range mode off and compare on, only `thr1` is used. With `sel_gt`=1 a beat passes when data >= thr1; with `sel_gt`=0 it passes when data < thr1.
- R2: With range mode on, thr1 <= thr2 and `sel_gt`=1, a beat passes when thr1 <= data <= thr2 (both endpoints pass).
- R3: With range mode on, thr1 <= thr2 and `sel_gt`=0, a beat passes when data < thr1 or data > thr2 (endpoints fail).
- R4: With range mode on, thr1 > thr2 and `sel_gt`=1, a beat passes when data >= thr1 or data <= thr2 (endpoints pass).
- R5: With range mode on, thr1 > thr2 and `sel_gt`=0, a beat passes when thr2 < data < thr1 (endpoints fail).
- R6: With `cmp_en`=0, every beat passes, whatever the thresholds and mode bits.
- R7: On the clock edge that takes a passing beat, `done_flag` becomes 1 and `result_q` takes the beat's data.
- R8: A failing beat changes neither `done_flag` nor `result_q`.
- R9: `rd_stb` clears `done_flag` at the next edge. If a passing beat arrives in the same cycle as `rd_stb`, the flag is set instead.
- R10: `irq` equals `done_flag` AND `irq_en` in every cycle.
- R11: While reset is asserted, `result_q` is 0, `done_flag` is 0 and `irq` is 0.
- R12: `conv_ready` is 1 in every cycle, so no beat is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_valid | input | 1 | Conversion result beat valid |
| conv_ready | output | 1 | Always 1; the block never stalls |
| conv_data | input | 16 | Unsigned result word (averaged or single) |
| cmp_en | input | 1 | Window compare enable |
| range_en | input | 1 | Two-threshold range mode |
| sel_gt | input | 1 | Compare sense select |
| thr1 | input | 16 | First threshold |
| thr2 | input | 16 | Second threshold |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | Result read strobe; clears the flag |
| result_q | output | 16 | Stored result register |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A read strobe and an accepted beat can land in the same cycle. When they do, the set must win (R9). A read strobe that coincides with a rejected beat must still clear the flag. The bench provokes both cases. It runs directed collisions and then a long random phase in which read strobes and beats are drawn independently. A behavioural model settles each edge as "set if accepted, else clear if read", and the flag, the result and the interrupt are compared with that model after every clock. Threshold pairs are drawn close to the data values so that every endpoint case in R1 to R5 is hit many times in both threshold orders.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;
  localparam int unsigned RES_W = 16;

  typedef enum logic [1:0] {
    WIN_SINGLE = 2'd0,
    WIN_ORDER  = 2'd1,
    WIN_SWAP   = 2'd2
  } win_mode_e;

  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/adcwin_cmp.sv
module adcwin_cmp
  import adcwin_pkg::*;
#(
  parameter int unsigned W = RES_W
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] thr1,
  input  logic [W-1:0] thr2,
  input  logic         range_en,
  input  logic         sel_gt,
  output logic         hit
);
  localparam int unsigned NTHR = 2;

  logic [W-1:0]    thr [NTHR];
  logic [NTHR-1:0] at_or_above;
  logic [NTHR-1:0] at_or_below;
  win_mode_e       mode;
  logic            closed_in, open_in;

  assign thr[0] = thr1;
  assign thr[1] = thr2;

  for (genvar i = 0; i < NTHR; i++) begin : g_edge
    assign at_or_above[i] = (data >= thr[i]);
    assign at_or_below[i] = (data <= thr[i]);
  end

  always_comb begin
    if (!range_en)          mode = WIN_SINGLE;
    else if (thr1 <= thr2)  mode = WIN_ORDER;
    else                    mode = WIN_SWAP;
  end

  always_comb begin
    closed_in = 1'b0;
    open_in   = 1'b0;
    hit       = 1'b0;
    unique case (mode)
      WIN_SINGLE: hit = sel_gt ? at_or_above[0] : !at_or_above[0];
      WIN_ORDER: begin
        closed_in = at_or_above[0] && at_or_below[1];
        hit       = sel_gt ? closed_in : !closed_in;
      end
      WIN_SWAP: begin
        open_in = !at_or_below[1] && !at_or_above[0];
        hit     = sel_gt ? !open_in : open_in;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adcwin_hold.sv
module adcwin_hold
  import adcwin_pkg::*;
#(
  parameter int unsigned W = RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] data,
  input  logic         rd_stb,
  output logic [W-1:0] result_q,
  output logic         flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (take) begin
        result_q <= data;
        flag_q   <= 1'b1;
      end else if (rd_stb) begin
        flag_q   <= 1'b0;
      end
    end
  end

  p_take_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flag_q && result_q == $past(data)));

  p_skip_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !rd_stb) |=> ($stable(result_q) && $stable(flag_q)));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !take) |=> (!flag_q && $stable(result_q)));

  p_set_beats_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && take) |=> flag_q);
endmodule

// File: rtl/adcwin_top.sv
module adcwin_top
  import adcwin_pkg::*;
#(
  parameter int unsigned W = RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_valid,
  output logic         conv_ready,
  input  logic [W-1:0] conv_data,
  input  logic         cmp_en,
  input  logic         range_en,
  input  logic         sel_gt,
  input  logic [W-1:0] thr1,
  input  logic [W-1:0] thr2,
  input  logic         irq_en,
  input  logic         rd_stb,
  output logic [W-1:0] result_q,
  output logic         done_flag,
  output logic         irq
);
  logic hit;
  logic take;

  assign conv_ready = 1'b1;

  adcwin_cmp #(.W(W)) u_cmp (
    .data     (conv_data),
    .thr1     (thr1),
    .thr2     (thr2),
    .range_en (range_en),
    .sel_gt   (sel_gt),
    .hit      (hit)
  );

  assign take = conv_valid && (!cmp_en || hit);

  adcwin_hold #(.W(W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .data     (conv_data),
    .rd_stb   (rd_stb),
    .result_q (result_q),
    .flag_q   (done_flag)
  );

  assign irq = done_flag & irq_en;

  p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !range_en) |-> (hit == (sel_gt ? !(conv_data < thr1) : (conv_data < thr1))));

  p_ord_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en && sel_gt && thr1 <= thr2) |-> (hit == !(conv_data < thr1 || conv_data > thr2)));

  p_ord_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en && !sel_gt && thr1 <= thr2) |-> (hit == (conv_data < thr1 || conv_data > thr2)));

  p_swap_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en && sel_gt && thr1 > thr2) |-> (hit == !(conv_data > thr2 && conv_data < thr1)));

  p_swap_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_en && !sel_gt && thr1 > thr2) |-> (hit == (conv_data > thr2 && conv_data < thr1)));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !cmp_en) |=> (done_flag && result_q == $past(conv_data)));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_flag |-> !irq);

  p_no_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready);
endmodule

// File: tb/adcwin_top_tb_top.sv
module adcwin_top_tb_top;
  localparam int W = 16;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_valid = 0, cmp_en = 0, range_en = 0, sel_gt = 0, irq_en = 0, rd_stb = 0;
  logic [W-1:0] conv_data = '0, thr1 = '0, thr2 = '0;
  logic conv_ready, done_flag, irq;
  logic [W-1:0] result_q;

  always #2.5 clk = ~clk;

  adcwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_data(conv_data), .cmp_en(cmp_en), .range_en(range_en), .sel_gt(sel_gt),
    .thr1(thr1), .thr2(thr2), .irq_en(irq_en), .rd_stb(rd_stb),
    .result_q(result_q), .done_flag(done_flag), .irq(irq)
  );

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  int m_res = 0;
  bit m_flag = 0;
  string flag_tag = "R11";
  string res_tag = "R11";

  function automatic bit ref_pass(bit c, bit r, bit s, int t1, int t2, int d);
    int lo, hi;
    bit closed_in, open_in;
    if (!c) return 1;
    if (!r) return s ? (d >= t1) : (d < t1);
    lo = (t1 < t2) ? t1 : t2;
    hi = (t1 < t2) ? t2 : t1;
    closed_in = (d >= lo) && (d <= hi);
    open_in = (d > lo) && (d < hi);
    if (t1 <= t2) return s ? closed_in : !closed_in;
    return s ? !open_in : open_in;
  endfunction

  function automatic string mode_tag(bit c, bit r, bit s, int t1, int t2);
    if (!c) return "R6";
    if (!r) return "R1";
    if (t1 <= t2) return s ? "R2" : "R3";
    return s ? "R4" : "R5";
  endfunction

  // reference model: one update per clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = 0; m_flag = 0; flag_tag = "R11"; res_tag = "R11";
    end else begin
      bit p;
      p = conv_valid && ref_pass(cmp_en, range_en, sel_gt, int'(thr1), int'(thr2), int'(conv_data));
      if (conv_valid) begin
        flag_tag = rd_stb ? "R9" : mode_tag(cmp_en, range_en, sel_gt, int'(thr1), int'(thr2));
        res_tag = p ? "R7" : "R8";
      end else begin
        flag_tag = rd_stb ? "R9" : "R8";
        res_tag = "R8";
      end
      if (p) begin m_res = int'(conv_data); m_flag = 1; end
      else if (rd_stb) m_flag = 0;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (done_flag !== m_flag) begin
        errors++;
        $display("FAIL %s done_flag actual=%0b expected=%0b", flag_tag, done_flag, m_flag);
      end
      if (int'(result_q) !== m_res) begin
        errors++;
        $display("FAIL %s result_q actual=%0d expected=%0d", res_tag, result_q, m_res);
      end
      if (irq !== (m_flag & irq_en)) begin
        errors++;
        $display("FAIL %s irq actual=%0b expected=%0b", rst_n ? "R10" : "R11", irq, m_flag & irq_en);
      end
      if (rst_n && conv_ready !== 1'b1) begin
        errors++;
        $display("FAIL R12 conv_ready actual=%0b expected=1", conv_ready);
      end
    end
  end

  task automatic beat(bit c, bit r, bit s, int t1, int t2, int d, bit rd);
    @(negedge clk);
    #1;
    cmp_en = c; range_en = r; sel_gt = s;
    thr1 = W'(t1); thr2 = W'(t2); conv_data = W'(d);
    conv_valid = 1; rd_stb = rd;
    @(negedge clk);
    #1;
    conv_valid = 0; rd_stb = 0;
  endtask

  task automatic read_only();
    @(negedge clk);
    #1;
    rd_stb = 1;
    @(negedge clk);
    #1;
    rd_stb = 0;
  endtask

  initial begin
    irq_en = 1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R1: single-threshold endpoints
    beat(1, 0, 1, 100, 0, 100, 0);  read_only();
    beat(1, 0, 1, 100, 0, 99, 0);
    beat(1, 0, 0, 100, 0, 100, 0);
    beat(1, 0, 0, 100, 0, 99, 0);   read_only();
    // R2/R3: ordered thresholds, both endpoints and interior/exterior
    for (int d = 9; d <= 21; d += 1) begin
      beat(1, 1, 1, 10, 20, d, 0); read_only();
      beat(1, 1, 0, 10, 20, d, 0); read_only();
    end
    // R4/R5: swapped thresholds
    for (int d = 9; d <= 21; d += 1) begin
      beat(1, 1, 1, 20, 10, d, 0); read_only();
      beat(1, 1, 0, 20, 10, d, 0); read_only();
    end
    // equal thresholds (ordered case)
    beat(1, 1, 1, 50, 50, 50, 0);
    beat(1, 1, 0, 50, 50, 50, 0); read_only();
    // R6: bypass with a window that would reject
    beat(0, 1, 1, 10, 20, 65535, 0);
    // R9: collision, passing beat wins over the read
    beat(0, 0, 0, 0, 0, 1234, 1);
    // R9: read with a failing beat clears
    beat(1, 1, 1, 10, 20, 5, 1);
    // R10: interrupt gating
    beat(0, 0, 0, 0, 0, 7, 0);
    @(negedge clk); #1 irq_en = 0;
    @(negedge clk); #1 irq_en = 1;
    // random phase
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      conv_valid = $urandom_range(0, 1);
      rd_stb = ($urandom_range(0, 3) == 0);
      cmp_en = ($urandom_range(0, 7) != 0);
      range_en = $urandom_range(0, 1);
      sel_gt = $urandom_range(0, 1);
      irq_en = $urandom_range(0, 1);
      thr1 = W'($urandom_range(0, 12));
      thr2 = W'($urandom_range(0, 12));
      conv_data = ($urandom_range(0, 15) == 0) ? W'($urandom) : W'($urandom_range(0, 12));
    end
    @(negedge clk);
    #1 conv_valid = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule